// File: doc/BRIEF.md
# Serial-programmed digital potentiometer wiper controller

This block sets the tap position of a 256-step digital potentiometer from a two-wire serial bus. It behaves as a write-only I2C slave. It watches the clock and data lines, recognises START and STOP conditions, and shifts in three bytes: a device address with a direction bit, a command, and a data value. It acknowledges each byte by pulling the data line low. Its only drive onto the bus is an open-drain pull-down request.

The command chooses what happens to the data value. It can set the live wiper register at once, or place the value in a nonvolatile store. A third command copies the present wiper setting into the store. The store is modelled as a register that survives reset. After each accepted write it shows a busy period, and writes that arrive during that period are dropped. When reset is released, the wiper register leaves its cleared state and takes the stored value.

The bus lines are resynchronised to the system clock, and all bus timing is oversampled. A write takes effect only on a STOP that follows a complete, acknowledged data byte.

Top module: `digipot_i2c_ctrl`

## Requirements
- R1: While `rst_n` is low, `wiper_o` is 0, `nv_busy_o` is 0 and `sda_pull_o` is 0 (data line released).
- R2: On the first clock edge after `rst_n` goes high, `wiper_o` takes the stored nonvolatile value. Before any write, that value is the parameter `NV_INIT`.
- R3: A transmission begins only with SDA falling while SCL is high. Bits clocked in without a preceding START are ignored: there is no acknowledge and no register change.
- R4: The address byte is acknowledged only when its upper 7 bits (MSB first) equal `DEV_ADDR` and its last bit (R/W) is 0. When that happens, the command byte and the data byte are also acknowledged. Each acknowledge holds `sda_pull_o` high for the whole ninth SCL pulse of the byte.
- R5: A non-matching address, or a read request (R/W = 1), is not acknowledged. The rest of the transmission is then ignored until the next START.
- R6: Command 0x11 followed by a data byte and STOP sets `wiper_o` to the data byte.
- R7: Command 0x21 writes the data byte into the nonvolatile store and leaves `wiper_o` unchanged. `nv_busy_o` is then high for exactly `NV_BUSY_CYC` clock cycles.
- R8: Command 0x61 writes the current `wiper_o` value into the nonvolatile store. The data byte is not used.
- R9: Any other command byte is acknowledged and has no effect on the wiper or the store.
- R10: A transmission is discarded when it is cut short before the data byte's acknowledge, when it is broken by a repeated START, or when it carries a byte after the data byte. An extra byte is not acknowledged.
- R11: A nonvolatile write that arrives while `nv_busy_o` is high is dropped. The busy period is not extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus) |
| sda_pull_o | output | 1 | 1 pulls the data line low; 0 releases it |
| wiper_o | output | 8 | Current wiper tap position |
| nv_busy_o | output | 1 | Nonvolatile store write in progress |

## Verification
Every bus edge reaches the logic two synchronizer stages later. An acknowledge therefore appears on `sda_pull_o` three clock edges after the SCL fall that ends a byte. A wiper update appears four edges after the SDA rise of STOP, and `nv_busy_o` rises one edge after that. The wiper load that follows reset appears on the first edge after release. The bench drives the bus from falling clock edges with three-cycle quarter periods. It reads the acknowledge in the middle of the SCL high phase and reads the wiper eight cycles after the STOP phase ends, so each sample falls well after its due edge and before the next stimulus. The length of the busy period is counted cycle by cycle at falling edges.

// File: rtl/digipot_pkg.sv
// Shared constants and types for the serial wiper controller.
// Assumes byte-wide transfers, MSB first.
package digipot_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CMD_SET_WIPER = 8'h11;
    localparam logic [BYTE_W-1:0] CMD_STORE_NV  = 8'h21;
    localparam logic [BYTE_W-1:0] CMD_COPY_NV   = 8'h61;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_ADDR,
        RX_CMD,
        RX_DATA,
        RX_DONE,
        RX_SKIP
    } rx_state_e;
endpackage

// File: rtl/pot_line_sync.sv
// Resynchronises one bus line to clk and gives its current and previous
// synchronised levels. Assumes the line idles high, so the reset state is all ones.
module pot_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic prev_o
);
    logic [STAGES:0] sh_q;

    // Shift chain: STAGES metastability flops plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-1:0], line_i};
    end

    assign level_o = sh_q[STAGES-1];
    assign prev_o  = sh_q[STAGES];
endmodule

// File: rtl/pot_i2c_rx.sv
// Write-only serial slave framer. Decodes START/STOP from synchronised levels,
// shifts in the address, command and data bytes, and requests acknowledge pulls.
// When the data byte is acknowledged and a STOP follows, it emits a one-cycle
// commit with the command and data.
// Assumes SDA changes only while SCL is low, except for START and STOP.
module pot_i2c_rx
    import digipot_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_now_i,
    input  logic              scl_prev_i,
    input  logic              sda_now_i,
    input  logic              sda_prev_i,
    output logic              ack_o,
    output logic              commit_o,
    output logic [BYTE_W-1:0] cmd_o,
    output logic [BYTE_W-1:0] data_o
);
    localparam int CNT_W = 4;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

    rx_state_e         state_q, next_byte;
    logic [CNT_W-1:0]  bitcnt_q;
    logic [BYTE_W-1:0] shreg_q;
    logic              ack_q, commit_q;
    logic [BYTE_W-1:0] cmd_q, data_q;
    logic              start_w, stop_w, rise_w, fall_w, addr_ok;

    // Bus events, derived from the current and previous line levels.
    always_comb begin
        start_w = scl_now_i & scl_prev_i & sda_prev_i & ~sda_now_i;
        stop_w  = scl_now_i & scl_prev_i & ~sda_prev_i & sda_now_i;
        rise_w  = scl_now_i & ~scl_prev_i;
        fall_w  = ~scl_now_i & scl_prev_i;
    end

    // Address match: 7-bit device address and a write direction bit.
    assign addr_ok = (shreg_q[BYTE_W-1:1] == DEV_ADDR) && !shreg_q[0];

    // Byte-field sequencing after each acknowledge.
    always_comb begin
        case (state_q)
            RX_ADDR: next_byte = RX_CMD;
            RX_CMD:  next_byte = RX_DATA;
            RX_DATA: next_byte = RX_DONE;
            default: next_byte = RX_SKIP;
        endcase
    end

    // Frame state machine: shifting, acknowledge control and commit on STOP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= RX_IDLE;
            bitcnt_q <= '0;
            shreg_q  <= '0;
            ack_q    <= 1'b0;
            commit_q <= 1'b0;
            cmd_q    <= '0;
            data_q   <= '0;
        end else begin
            commit_q <= 1'b0;
            if (start_w) begin
                state_q  <= RX_ADDR;
                bitcnt_q <= '0;
                ack_q    <= 1'b0;
            end else if (stop_w) begin
                commit_q <= (state_q == RX_DONE);
                state_q  <= RX_IDLE;
                bitcnt_q <= '0;
                ack_q    <= 1'b0;
            end else begin
                case (state_q)
                    RX_ADDR, RX_CMD, RX_DATA: begin
                        if (rise_w && bitcnt_q < LAST_BIT) begin
                            shreg_q  <= {shreg_q[BYTE_W-2:0], sda_now_i};
                            bitcnt_q <= bitcnt_q + CNT_W'(1);
                        end else if (fall_w && bitcnt_q == LAST_BIT) begin
                            bitcnt_q <= ACK_BIT;
                            if (state_q == RX_ADDR && !addr_ok) state_q <= RX_SKIP;
                            else                                ack_q   <= 1'b1;
                            if (state_q == RX_CMD)  cmd_q  <= shreg_q;
                            if (state_q == RX_DATA) data_q <= shreg_q;
                        end else if (fall_w && bitcnt_q == ACK_BIT) begin
                            ack_q    <= 1'b0;
                            bitcnt_q <= '0;
                            state_q  <= next_byte;
                        end
                    end
                    RX_DONE: if (fall_w) state_q <= RX_SKIP;
                    default: ;
                endcase
            end
        end
    end

    assign ack_o    = ack_q;
    assign commit_o = commit_q;
    assign cmd_o    = cmd_q;
    assign data_o   = data_q;

    // R3
    evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_w, stop_w, rise_w, fall_w}));
    // R4
    ack_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |-> (bitcnt_q == ACK_BIT && state_q != RX_SKIP && state_q != RX_IDLE));
    // R10
    commit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_q |-> ($past(state_q) == RX_DONE && $past(stop_w)));
endmodule

// File: rtl/pot_nv_store.sv
// Model of the nonvolatile wiper store. The stored value is not cleared by
// reset (it starts at NV_INIT). An accepted write takes the value at once and
// then reports busy for NV_BUSY_CYC cycles. Writes arriving while busy are
// dropped. Assumes NV_BUSY_CYC >= 1.
module pot_nv_store
    import digipot_pkg::*;
#(
    parameter logic [BYTE_W-1:0] NV_INIT     = 8'h80,
    parameter int                NV_BUSY_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    output logic [BYTE_W-1:0] value_o,
    output logic              busy_o
);
    localparam int CNT_W = $clog2(NV_BUSY_CYC + 1);

    logic [BYTE_W-1:0] value_q = NV_INIT;
    logic [CNT_W-1:0]  cnt_q;
    logic              busy;

    assign busy = (cnt_q != '0);

    // Storage cell: kept across reset, written only when idle.
    always_ff @(posedge clk) begin
        if (wr_req_i && !busy) value_q <= wr_data_i;
    end

    // Busy timer: loaded by an accepted write, counts down to idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (wr_req_i && !busy) cnt_q <= CNT_W'(NV_BUSY_CYC);
        else if (busy)              cnt_q <= cnt_q - CNT_W'(1);
    end

    assign value_o = value_q;
    assign busy_o  = busy;

    // R11
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_i && busy) |=> $stable(value_q));
    // R7
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_req_i));
endmodule

// File: rtl/pot_wiper_ctrl.sv
// Holds the live wiper register. Loads it from the store on the first cycle
// after reset, then carries out committed commands: set the wiper, store the
// data, or store a copy of the wiper. Assumes a commit never falls in the
// cycle after reset release (a STOP needs bus time first).
module pot_wiper_ctrl
    import digipot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [BYTE_W-1:0] cmd_i,
    input  logic [BYTE_W-1:0] data_i,
    input  logic [BYTE_W-1:0] nv_value_i,
    output logic [BYTE_W-1:0] wiper_o,
    output logic              nv_req_o,
    output logic [BYTE_W-1:0] nv_data_o
);
    logic [BYTE_W-1:0] wiper_q, nv_data_q;
    logic              boot_q, nv_req_q;

    // Boot load and command execution.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wiper_q   <= '0;
            boot_q    <= 1'b1;
            nv_req_q  <= 1'b0;
            nv_data_q <= '0;
        end else begin
            nv_req_q <= 1'b0;
            if (boot_q) begin
                wiper_q <= nv_value_i;
                boot_q  <= 1'b0;
            end else if (commit_i) begin
                case (cmd_i)
                    CMD_SET_WIPER: wiper_q <= data_i;
                    CMD_STORE_NV: begin
                        nv_req_q  <= 1'b1;
                        nv_data_q <= data_i;
                    end
                    CMD_COPY_NV: begin
                        nv_req_q  <= 1'b1;
                        nv_data_q <= wiper_q;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign wiper_o   = wiper_q;
    assign nv_req_o  = nv_req_q;
    assign nv_data_o = nv_data_q;

    // R6
    wiper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(boot_q) && !($past(commit_i) && $past(cmd_i) == CMD_SET_WIPER))
            |-> $stable(wiper_q));
    // R9
    nv_req_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nv_req_q |-> ($past(commit_i) &&
            ($past(cmd_i) == CMD_STORE_NV || $past(cmd_i) == CMD_COPY_NV)));
endmodule

// File: rtl/digipot_i2c_ctrl.sv
// Top level of the serial wiper controller. Synchronises both bus lines, frames
// write transmissions, runs wiper commands and drives the nonvolatile store model.
// Assumes clk runs several times faster than SCL, so every bus phase spans more
// than SYNC_STAGES + 1 clock cycles.
module digipot_i2c_ctrl
    import digipot_pkg::*;
#(
    parameter logic [6:0]        DEV_ADDR    = 7'h2C,
    parameter logic [BYTE_W-1:0] NV_INIT     = 8'h80,
    parameter int                NV_BUSY_CYC = 16,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    output logic [BYTE_W-1:0] wiper_o,
    output logic              nv_busy_o
);
    logic              scl_now, scl_prev, sda_now, sda_prev;
    logic              commit;
    logic [BYTE_W-1:0] cmd, data, nv_value, nv_data;
    logic              nv_req;

    pot_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i), .level_o(scl_now), .prev_o(scl_prev)
    );
    pot_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i), .level_o(sda_now), .prev_o(sda_prev)
    );

    pot_i2c_rx #(.DEV_ADDR(DEV_ADDR)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .scl_now_i(scl_now), .scl_prev_i(scl_prev),
        .sda_now_i(sda_now), .sda_prev_i(sda_prev),
        .ack_o(sda_pull_o), .commit_o(commit), .cmd_o(cmd), .data_o(data)
    );

    pot_wiper_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .commit_i(commit), .cmd_i(cmd), .data_i(data),
        .nv_value_i(nv_value), .wiper_o(wiper_o),
        .nv_req_o(nv_req), .nv_data_o(nv_data)
    );

    pot_nv_store #(.NV_INIT(NV_INIT), .NV_BUSY_CYC(NV_BUSY_CYC)) u_nv (
        .clk(clk), .rst_n(rst_n),
        .wr_req_i(nv_req), .wr_data_i(nv_data),
        .value_o(nv_value), .busy_o(nv_busy_o)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (!sda_pull_o && !nv_busy_o));
endmodule

// File: tb/digipot_i2c_ctrl_bench.sv
// Bench: drives the serial bus from falling clock edges and checks acknowledges,
// wiper values and the busy period against values computed from the requirements.
module digipot_i2c_ctrl_bench;
    localparam logic [6:0] DEV   = 7'h2C;
    localparam logic [7:0] NVI   = 8'h80;
    localparam int         BUSYC = 600;
    localparam int         Q     = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       sda_pull, nv_busy, sda_bus;
    logic [7:0] wiper;
    int         tests = 0, fails = 0, busy_cyc = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;
    assign sda_bus = sda_m & ~sda_pull;

    digipot_i2c_ctrl #(.DEV_ADDR(DEV), .NV_INIT(NVI), .NV_BUSY_CYC(BUSYC)) u_digipot_i2c_ctrl (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_pull_o(sda_pull), .wiper_o(wiper), .nv_busy_o(nv_busy)
    );

    always @(negedge clk) if (nv_busy) busy_cyc <= busy_cyc + 1;

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic qw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qw(Q); scl_m = 1'b1; qw(Q); sda_m = 1'b0; qw(Q); scl_m = 1'b0; qw(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qw(Q); scl_m = 1'b1; qw(Q); sda_m = 1'b1; qw(2 * Q);
    endtask

    task automatic bus_bit(input logic b);
        sda_m = b; qw(Q); scl_m = 1'b1; qw(2 * Q); scl_m = 1'b0; qw(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) bus_bit(b[i]);
        sda_m = 1'b1; qw(Q); scl_m = 1'b1; qw(Q);
        ack = sda_pull;
        qw(Q); scl_m = 1'b0; qw(Q);
    endtask

    task automatic xfer(input logic [6:0] a, input logic rw, input logic [7:0] c,
                        input logic [7:0] d, output logic [2:0] acks);
        bus_start();
        send_byte({a, rw}, acks[2]);
        send_byte(c, acks[1]);
        send_byte(d, acks[0]);
        bus_stop();
        qw(8);
    endtask

    task automatic do_reset(input logic [7:0] exp, input string tag);
        rst_n = 1'b0; qw(3); rst_n = 1'b1; qw(1);
        chk(tag, wiper, exp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    initial begin
        logic [2:0] acks;
        logic       a;
        logic [7:0] v;

        qw(4);
        // R1: reset state
        chk("R1 wiper", wiper, 0);
        chk("R1 pull", sda_pull, 0);
        chk("R1 busy", nv_busy, 0);
        rst_n = 1'b1; qw(1);
        // R2: stored value loaded on first edge after release
        chk("R2 boot load", wiper, NVI);

        // R6 / R4: every tap value through a volatile write
        for (int k = 0; k < 256; k++) begin
            v = 8'((k * 37 + 5) & 255);
            xfer(DEV, 1'b0, 8'h11, v, acks);
            chk("R4 acks", acks, 3'b111);
            chk("R6 wiper", wiper, v);
        end

        // R4 / R5: address sweep, acknowledge only on a match
        for (int ad = 0; ad < 128; ad++) begin
            bus_start();
            send_byte({7'(ad), 1'b0}, a);
            bus_stop();
            chk("R4 R5 addr ack", a, (7'(ad) == DEV) ? 1 : 0);
        end

        xfer(DEV, 1'b0, 8'h11, 8'h42, acks);
        // R5: read request and wrong address ignored
        xfer(DEV, 1'b1, 8'h11, 8'h55, acks);
        chk("R5 read acks", acks, 3'b000);
        chk("R5 read wiper", wiper, 8'h42);
        xfer(DEV ^ 7'h01, 1'b0, 8'h11, 8'h56, acks);
        chk("R5 mismatch acks", acks, 3'b000);
        chk("R5 mismatch wiper", wiper, 8'h42);

        // R3: bytes clocked without a START are ignored
        send_byte({DEV, 1'b0}, acks[2]);
        send_byte(8'h11, acks[1]);
        send_byte(8'h77, acks[0]);
        bus_stop(); qw(8);
        chk("R3 no-start acks", acks, 3'b000);
        chk("R3 no-start wiper", wiper, 8'h42);

        // R9: unknown command acknowledged, no effect
        busy_cyc = 0;
        xfer(DEV, 1'b0, 8'h33, 8'h99, acks);
        qw(20);
        chk("R9 acks", acks, 3'b111);
        chk("R9 wiper", wiper, 8'h42);
        chk("R9 busy", busy_cyc, 0);

        // R10: truncated data byte
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h11, a);
        for (int i = 0; i < 4; i++) bus_bit(1'b1);
        bus_stop(); qw(8);
        chk("R10 truncated", wiper, 8'h42);
        // R10: repeated START after the data byte
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h11, a);
        send_byte(8'h0F, a);
        bus_start();
        bus_stop(); qw(8);
        chk("R10 restart", wiper, 8'h42);
        // R10: extra byte after the data byte
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h11, a);
        send_byte(8'h0E, a);
        send_byte(8'hAA, a);
        bus_stop(); qw(8);
        chk("R10 extra nack", a, 0);
        chk("R10 extra wiper", wiper, 8'h42);

        // R7: store write leaves wiper, busy period length, restore at reset
        xfer(DEV, 1'b0, 8'h11, 8'h5A, acks);
        busy_cyc = 0;
        xfer(DEV, 1'b0, 8'h21, 8'hC3, acks);
        chk("R7 wiper kept", wiper, 8'h5A);
        chk("R7 busy high", nv_busy, 1);
        qw(BUSYC + 10);
        chk("R7 busy length", busy_cyc, BUSYC);
        do_reset(8'hC3, "R7 restore");

        // R11: second store write inside the busy period is dropped
        busy_cyc = 0;
        xfer(DEV, 1'b0, 8'h21, 8'h17, acks);
        xfer(DEV, 1'b0, 8'h21, 8'h99, acks);
        qw(BUSYC + 10);
        chk("R11 busy not extended", busy_cyc, BUSYC);
        do_reset(8'h17, "R11 restore");

        // R8: copy of the wiper into the store
        xfer(DEV, 1'b0, 8'h11, 8'h3C, acks);
        xfer(DEV, 1'b0, 8'h61, 8'hEE, acks);
        chk("R8 wiper kept", wiper, 8'h3C);
        qw(BUSYC + 10);
        xfer(DEV, 1'b0, 8'h11, 8'h00, acks);
        chk("R8 wiper cleared", wiper, 8'h00);
        do_reset(8'h3C, "R8 restore");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule